// File: doc/BRIEF.md
# Schedule Tick Syntonizer

This block produces the strobe that moves a time-aware egress schedule from one interval to the next. It counts cycles of the scheduler clock and emits one strobe per delta, where a delta is nominally 25 ticks, or 200 ns at 8 ns per tick. The PTP time-of-day counter runs from the same oscillator, but a servo may speed it up or slow it down. Left alone, the scheduler would drift away from PTP time.

To prevent that, the block opens a measurement window when the schedule starts. The window closes once the PTP count has advanced by the programmed correction period. At that point the block compares the PTP time that elapsed, converted to ticks, with the ticks it actually counted. The signed difference is reported and added to a pending adjustment. Later deltas are then shortened or lengthened by whole ticks, with a per-delta limit, until the pending adjustment is used up. A restart clears all measurement and adjustment state and waits again for the programmed start time, which is how a stepped PTP clock is recovered.

Top module: `sched_tick_syntonizer`

## Requirements
- R1: After reset, `delta_strobe` and `running` are 0 and `drift_ticks` is 0.
- R2: While `running` is 0, no strobe is produced. `running` rises on the cycle after the first edge at which `ptp_ns >= start_ns`. The first strobe follows 25 cycles after that edge.
- R3: With no pending adjustment, strobes are exactly 25 cycles apart and each is one cycle wide.
- R4: A window opens at the start edge and at every window close. It closes at the first edge at which `ptp_ns` minus the value captured at its opening is at least `corr_period_ns`. The drift is `floor(elapsed_ns / 8)` minus the number of edges since the opening. A positive value means PTP time ran ahead. The drift becomes visible on `drift_ticks` after that edge.
- R5: `drift_ticks` holds its value between window closes.
- R6: A positive pending adjustment shortens deltas and a negative one lengthens them. Each delta differs from 25 by at most 5 ticks, so every delta is between 20 and 30 cycles. Because no delta is shorter than 20 ticks, any 20-tick span receives at most 5 ticks of correction.
- R7: A pending adjustment larger than 5 is spread over successive deltas, each taking the full 5 until the remainder fits. The total of (25 − delta length) over all finished deltas equals the sum of the reported drifts once the adjustment is used up.
- R8: If a window closes on the same edge that a new delta begins, that delta already includes the new drift.
- R9: A `restart` edge clears the drift, the pending adjustment and any strobe, and drops `running`. This holds even if the start condition is met on that same edge. Start comparison is then re-armed, and the block starts on the next edge at which `ptp_ns >= start_ns`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptp_ns | input | PTP_W | PTP nanosecond count, same oscillator |
| start_ns | input | PTP_W | PTP time at which the schedule starts |
| corr_period_ns | input | PTP_W | Correction window length in PTP nanoseconds |
| restart | input | 1 | Clears state and re-arms the start comparison |
| delta_strobe | output | 1 | One-cycle pulse at the end of each delta |
| drift_ticks | output | DRIFT_W | Signed drift measured in the last window |
| running | output | 1 | Schedule timebase active |

## Verification
Two events can fall on the same edge: the close of a correction window and the start of a new delta. The bench forces this by adding one PTP jump of 24 ns and choosing a period of 424 ns. With these values the first window closes with a drift of +3 exactly on the edge where the second delta ends. The check is that the third delta lasts 22 cycles. A design that applied the drift one delta later would show 25 there and 22 one delta later.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic {
        ARM_WAIT = 1'b0,
        ARM_RUN  = 1'b1
    } arm_state_e;

endpackage

// File: rtl/sts_start_arm.sv
module sts_start_arm
    import sts_pkg::*;
#(
    parameter int PTP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PTP_W-1:0] ptp_ns,
    input  logic [PTP_W-1:0] start_ns,
    output logic             go,
    output logic             run
);

    typedef struct packed {
        arm_state_e state;
    } arm_t;

    arm_t q, d;

    always_comb begin
        d   = q;
        go  = (q.state == ARM_WAIT) && !clear && (ptp_ns >= start_ns);
        if (clear) begin
            d.state = ARM_WAIT;
        end else if (go) begin
            d.state = ARM_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: ARM_WAIT};
        else        q <= d;
    end

    assign run = (q.state == ARM_RUN);

    // R2: the timebase only starts once the start time has been reached
    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(ptp_ns >= start_ns));

    // R9: restart always leaves the block waiting
    p_restart_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !run);

endmodule

// File: rtl/sts_drift_meter.sv
module sts_drift_meter #(
    parameter int PTP_W        = 32,
    parameter int DRIFT_W      = 16,
    parameter int TICK_NS_LOG2 = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      go,
    input  logic                      run,
    input  logic [PTP_W-1:0]          ptp_ns,
    input  logic [PTP_W-1:0]          period_ns,
    output logic                      boundary,
    output logic signed [DRIFT_W-1:0] drift_now,
    output logic signed [DRIFT_W-1:0] drift_q
);

    typedef struct packed {
        logic [PTP_W-1:0]          win_start;
        logic [PTP_W-1:0]          win_ticks;
        logic signed [DRIFT_W-1:0] drift;
    } meter_t;

    meter_t q, d;

    logic [PTP_W-1:0]      elapsed;
    logic [PTP_W-1:0]      expected;
    logic signed [PTP_W:0] diff;

    always_comb begin
        elapsed   = ptp_ns - q.win_start;
        expected  = elapsed >> TICK_NS_LOG2;
        diff      = $signed({1'b0, expected}) - $signed({1'b0, q.win_ticks});
        drift_now = DRIFT_W'(diff);
        boundary  = run && !clear && (elapsed >= period_ns);

        d = q;
        if (clear) begin
            d = '0;
        end else if (go) begin
            d.win_start = ptp_ns;
            d.win_ticks = PTP_W'(1);
        end else if (boundary) begin
            d.win_start = ptp_ns;
            d.win_ticks = PTP_W'(1);
            d.drift     = drift_now;
        end else if (run) begin
            d.win_ticks = q.win_ticks + PTP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drift_q = q.drift;

    // R5: reported drift only changes at a window close or a restart
    p_drift_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !clear) |=> $stable(drift_q));

    // R9: restart zeroes the reported drift
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (drift_q == '0));

endmodule

// File: rtl/sts_delta_gen.sv
module sts_delta_gen #(
    parameter int NOM_TICKS = 25,
    parameter int MAX_STEP  = 5,
    parameter int DRIFT_W   = 16,
    parameter int RESID_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      go,
    input  logic                      run,
    input  logic                      boundary,
    input  logic signed [DRIFT_W-1:0] drift_now,
    output logic                      strobe
);

    localparam int LEN_W = $clog2(NOM_TICKS + MAX_STEP + 1);
    localparam logic signed [RESID_W-1:0] MAX_S = RESID_W'(MAX_STEP);
    localparam logic signed [RESID_W-1:0] NOM_S = RESID_W'(NOM_TICKS);

    typedef struct packed {
        logic [LEN_W-1:0]          phase;
        logic [LEN_W-1:0]          len;
        logic signed [RESID_W-1:0] resid;
        logic                      strobe;
    } gen_t;

    gen_t q, d;

    logic signed [RESID_W-1:0] add_v;
    logic signed [RESID_W-1:0] resid_eff;
    logic signed [RESID_W-1:0] step;
    logic signed [RESID_W-1:0] len_s;
    logic                      delta_end;
    logic                      begin_delta;

    always_comb begin
        add_v     = boundary ? RESID_W'(drift_now) : RESID_W'(0);
        resid_eff = q.resid + add_v;
        if (resid_eff > MAX_S)       step = MAX_S;
        else if (resid_eff < -MAX_S) step = -MAX_S;
        else                         step = resid_eff;
        len_s       = NOM_S - step;
        delta_end   = run && (q.phase == q.len - LEN_W'(1));
        begin_delta = go || delta_end;

        d = q;
        if (clear) begin
            d = '0;
        end else begin
            d.strobe = delta_end;
            d.resid  = resid_eff;
            if (begin_delta) begin
                d.phase = '0;
                d.len   = LEN_W'(len_s);
                d.resid = resid_eff - step;
            end else if (run) begin
                d.phase = q.phase + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign strobe = q.strobe;

    // R6: every running delta stays within the step limit around nominal
    p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(q.len) >= NOM_TICKS - MAX_STEP && int'(q.len) <= NOM_TICKS + MAX_STEP));

    // R3: a strobe lasts one cycle
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R2: no strobe follows a cycle without a running timebase
    p_silent_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !strobe);

endmodule

// File: rtl/sched_tick_syntonizer.sv
module sched_tick_syntonizer #(
    parameter int PTP_W        = 32,
    parameter int DRIFT_W      = 16,
    parameter int RESID_W      = 16,
    parameter int NOM_TICKS    = 25,
    parameter int MAX_STEP     = 5,
    parameter int TICK_NS_LOG2 = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PTP_W-1:0]          ptp_ns,
    input  logic [PTP_W-1:0]          start_ns,
    input  logic [PTP_W-1:0]          corr_period_ns,
    input  logic                      restart,
    output logic                      delta_strobe,
    output logic signed [DRIFT_W-1:0] drift_ticks,
    output logic                      running
);

    logic                      go;
    logic                      run;
    logic                      boundary;
    logic signed [DRIFT_W-1:0] drift_now;

    sts_start_arm #(.PTP_W(PTP_W)) arm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .ptp_ns   (ptp_ns),
        .start_ns (start_ns),
        .go       (go),
        .run      (run)
    );

    sts_drift_meter #(
        .PTP_W        (PTP_W),
        .DRIFT_W      (DRIFT_W),
        .TICK_NS_LOG2 (TICK_NS_LOG2)
    ) meter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .go        (go),
        .run       (run),
        .ptp_ns    (ptp_ns),
        .period_ns (corr_period_ns),
        .boundary  (boundary),
        .drift_now (drift_now),
        .drift_q   (drift_ticks)
    );

    sts_delta_gen #(
        .NOM_TICKS (NOM_TICKS),
        .MAX_STEP  (MAX_STEP),
        .DRIFT_W   (DRIFT_W),
        .RESID_W   (RESID_W)
    ) gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .go        (go),
        .run       (run),
        .boundary  (boundary),
        .drift_now (drift_now),
        .strobe    (delta_strobe)
    );

    assign running = run;

    // R2: strobes appear only while the timebase runs
    p_armed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !delta_strobe);

endmodule

// File: tb/sched_tick_syntonizer_tb_top.sv
module sched_tick_syntonizer_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        restart;
    logic [31:0] ptp_ns;
    logic [31:0] start_ns;
    logic [31:0] corr_period_ns;
    logic        delta_strobe;
    logic        running;
    logic signed [15:0] drift_ticks;

    sched_tick_syntonizer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ptp_ns         (ptp_ns),
        .start_ns       (start_ns),
        .corr_period_ns (corr_period_ns),
        .restart        (restart),
        .delta_strobe   (delta_strobe),
        .drift_ticks    (drift_ticks),
        .running        (running)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int inc = 8;
    int extra = 0;
    int wstart, wn, exp_drift;
    int last_s, nl;
    int lens [0:255];
    int tot_drift, tot_short;
    bit prev_strobe;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        int seen, st, ln;
        bit rb, rs;
        seen = int'(ptp_ns);
        st   = int'(start_ns);
        rb   = running;
        rs   = restart;
        @(posedge clk);
        #1;
        cyc++;
        if (rs) begin
            wn = 0;
            exp_drift = 0;
        end else if (rb) begin
            wn++;
            if (seen - wstart >= int'(corr_period_ns)) begin
                exp_drift = ((seen - wstart) >>> 3) - wn;
                tot_drift += exp_drift;
                wstart = seen;
                wn = 0;
                check(int'(drift_ticks) == exp_drift, "R4 drift at window close", int'(drift_ticks), exp_drift);
            end else begin
                check(int'(drift_ticks) == exp_drift, "R5 drift held", int'(drift_ticks), exp_drift);
            end
        end else if (running) begin
            check(seen >= st, "R2 start only at start time", seen, st);
            wstart = seen;
            wn = 0;
            last_s = cyc;
            nl = 0;
        end else if (rst_n) begin
            check(seen < st, "R2 starts when time reached", seen, st);
        end
        if (delta_strobe) begin
            check(running, "R2 strobe while idle", 0, 1);
            check(!prev_strobe, "R3 single-cycle strobe", 1, 0);
            ln = cyc - last_s;
            last_s = cyc;
            if (nl < 256) lens[nl] = ln;
            nl++;
            check(ln >= 20 && ln <= 30, "R6 delta length bound", ln, 25);
            tot_short += 25 - ln;
        end
        prev_strobe = delta_strobe;
        ptp_ns = ptp_ns + 32'(inc + extra);
        extra = 0;
    endtask

    task automatic do_restart();
        restart = 1'b1;
        tick();
        restart = 1'b0;
        check(!running, "R9 restart drops running", int'(running), 0);
        check(drift_ticks == 0, "R9 restart clears drift", int'(drift_ticks), 0);
        check(!delta_strobe, "R9 restart clears strobe", int'(delta_strobe), 0);
        tot_drift = 0;
        tot_short = 0;
        nl = 0;
    endtask

    task automatic wait_start();
        for (int k = 0; k < 300 && !running; k++) tick();
        check(running, "R2 started", int'(running), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        restart = 1'b0;
        ptp_ns = 32'd0;
        start_ns = 32'd1000;
        corr_period_ns = 32'd100000;
        tot_drift = 0;
        tot_short = 0;
        nl = 0;
        exp_drift = 0;
        repeat (4) tick();
        check(!delta_strobe, "R1 strobe low after reset", int'(delta_strobe), 0);
        check(!running, "R1 running low after reset", int'(running), 0);
        check(drift_ticks == 0, "R1 drift zero after reset", int'(drift_ticks), 0);
        rst_n = 1'b1;

        // Nominal timebase: R2 and R3
        wait_start();
        repeat (300) tick();
        check(nl >= 10, "R3 strobe count", nl, 10);
        check(lens[0] == 25, "R2 first strobe 25 cycles after start", lens[0], 25);
        for (int i = 0; i < nl && i < 256; i++)
            check(lens[i] == 25, "R3 nominal spacing", lens[i], 25);

        // Sweep of PTP rates and correction periods: R4..R7
        foreach (lens[i]) lens[i] = 0;
        for (int r = 0; r < 2; r++) begin
            for (int p = 0; p < 4; p++) begin
                int wrong, adj;
                do_restart();
                corr_period_ns = (p == 0) ? 32'd304 : (p == 1) ? 32'd504 : (p == 2) ? 32'd1000 : 32'd1601;
                start_ns = ptp_ns + 32'd40;
                inc = (r == 0) ? 9 : 7;
                tot_drift = 0;
                tot_short = 0;
                wait_start();
                repeat (1200) tick();
                inc = 8;
                repeat (900) tick();
                check(tot_short == tot_drift, "R7 adjustment matches drift", tot_short, tot_drift);
                wrong = 0;
                adj = 0;
                for (int i = 0; i < nl && i < 256; i++) begin
                    if (r == 0 && lens[i] > 25) wrong++;
                    if (r == 1 && lens[i] < 25) wrong++;
                    if (lens[i] != 25) adj++;
                end
                check(wrong == 0, "R6 adjustment direction", wrong, 0);
                check(adj > 0, "R6 deltas adjusted", adj, 1);
            end
        end

        // Window close coincides with delta start: R8
        do_restart();
        corr_period_ns = 32'd424;
        start_ns = ptp_ns + 32'd40;
        inc = 8;
        wait_start();
        repeat (9) tick();
        extra = 24;
        repeat (140) tick();
        check(lens[1] == 25, "R8 delta before coincident close", lens[1], 25);
        check(lens[2] == 22, "R8 delta starting on close edge", lens[2], 22);
        check(lens[3] == 25, "R8 delta after correction", lens[3], 25);

        // Large drift spread over several deltas: R7
        do_restart();
        corr_period_ns = 32'd2000;
        start_ns = ptp_ns + 32'd40;
        wait_start();
        repeat (9) tick();
        extra = 96;
        repeat (390) tick();
        check(lens[9] == 25, "R7 delta before spread", lens[9], 25);
        check(lens[10] == 20, "R7 first capped delta", lens[10], 20);
        check(lens[11] == 20, "R7 second capped delta", lens[11], 20);
        check(lens[12] == 23, "R7 remainder delta", lens[12], 23);
        check(lens[13] == 25, "R7 back to nominal", lens[13], 25);

        // Restart with start condition already met, then re-arm: R9
        do_restart();
        corr_period_ns = 32'd504;
        start_ns = ptp_ns + 32'd40;
        inc = 9;
        wait_start();
        repeat (300) tick();
        check(drift_ticks != 0, "R9 drift nonzero before restart", int'(drift_ticks), 1);
        do_restart();
        tick();
        check(running, "R9 re-armed start fires", int'(running), 1);
        inc = 8;
        do_restart();
        start_ns = ptp_ns + 32'd2000;
        begin
            int cnt = 0;
            for (int k = 0; k < 100; k++) begin
                tick();
                if (delta_strobe || running) cnt++;
            end
            check(cnt == 0, "R9 quiet until new start", cnt, 0);
        end
        wait_start();
        repeat (60) tick();
        check(lens[0] == 25, "R9 clean restart first delta", lens[0], 25);
        check(lens[1] == 25, "R9 residual cleared", lens[1], 25);

        summary();
        $finish;
    end

endmodule